// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core whose subroutine calls move a window over a large circular pool of physical registers. A call advances the window instead of spilling registers to memory, and a return retreats it. Instructions name 32 architectural registers with 5-bit numbers. Numbers 0 to 7 select eight global registers that sit outside the pool. Numbers 8 to 31 select three groups of eight windowed registers: outs, locals and ins.

With the default parameters there are 128 physical 32-bit registers, arranged as 8 windows of 16 registers each. Each window owns one group of outs and one group of locals. Its ins are the outs of the window below it. One advance step therefore turns the caller's outs into the callee's ins without copying any data.

The block has two combinational read ports and one write port that writes on the clock edge. It also has advance and retreat request inputs, a per-window invalid mask, the current window pointer, and one-cycle overflow and underflow trap flags. Trap handling, spilling, decoding and forwarding belong to other blocks.

Top module: `winreg_file`

## Requirements
- R1: While reset is held and in the first cycle after it, the window pointer reads 0 and both trap flags read 0.
- R2: Architectural register 0 always reads as 0 on both read ports, and a write to it has no effect.
- R3: Registers 1 to 7 are globals. The same register is visible in every window, and its value survives advance and retreat.
- R4: With window pointer w, outs (registers 8+k) map to physical index 16w+k. Locals (registers 16+k) map to 16w+8+k. Ins (registers 24+k) map to 16·((w−1) mod 8)+k. A value written to out k is therefore read as in k after one advance.
- R5: An advance request moves the pointer to (w+1) mod 8, and a retreat request moves it to (w−1) mod 8, when the mask bit of the target window is 0. The mask is an 8-bit input in which bit i stands for window i.
- R6: If the mask bit of the target window is 1, the pointer stays where it is. The cycle after the request, the overflow flag (for an advance) or the underflow flag (for a retreat) is 1 for one cycle.
- R7: Advance and retreat requested in the same cycle move nothing and raise no flag.
- R8: A write in the same cycle as a move uses the window pointer from before the move.
- R9: Reading a register in the cycle it is written returns its old value. The new value is visible from the next cycle.
- R10: The pointer wraps from 7 to 0. After eight advances the original locals are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 32 | Write data |
| adv_req | input | 1 | Advance the window (call) |
| ret_req | input | 1 | Retreat the window (return) |
| inval_mask | input | 8 | Invalid-window mask, one bit per window |
| cwp | output | 3 | Current window pointer |
| ovf_flag | output | 1 | Advance blocked by the mask |
| unf_flag | output | 1 | Retreat blocked by the mask |

## Verification
The bench pushes a write into outs together with an advance and reads the value back through the next window's ins. A design that applied the new pointer at once would lose that value into the wrong window. It blocks moves with the mask at both wrap edges and requests advance and retreat together. A design that moved anyway, or flagged in the wrong cycle, would show up as a pointer mismatch or a missing or extra flag. It also reads registers in the cycle they are written, writes to register 0, and runs eight advances in a row to show that the locals survive the wrap. A reference model checks long random mixes of these operations read by read.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  // Register class, decoded from the two upper bits of the register number.
  typedef enum logic [1:0] {
    REG_GLOBAL = 2'd0,
    REG_OUT    = 2'd1,
    REG_LOCAL  = 2'd2,
    REG_IN     = 2'd3
  } reg_class_e;

  function automatic reg_class_e classify(input logic [1:0] grp);
    return reg_class_e'(grp);
  endfunction

endpackage

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int GRP  = 8,
  localparam int PTRW = $clog2(NWIN),
  localparam int GSH  = $clog2(GRP),
  localparam int AW   = GSH + 2,
  localparam int PW   = PTRW + GSH + 1
) (
  input  logic [PTRW-1:0] cwp,
  input  logic [AW-1:0]   idx,
  output logic            is_glob,
  output logic [PW-1:0]   phys
);

  reg_class_e      cls;
  logic [PTRW-1:0] win;
  logic [GSH-1:0]  off;

  // Ins belong to the previous window. The modulo wrap comes from the pointer width.
  always_comb begin
    cls     = classify(idx[AW-1:GSH]);
    off     = idx[GSH-1:0];
    win     = (cls == REG_IN) ? (cwp - PTRW'(1)) : cwp;
    is_glob = (cls == REG_GLOBAL);
    phys    = {win, (cls == REG_LOCAL), off};
  end

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int DW    = 32,
  parameter int GRP   = 8,
  parameter int PW    = 7,
  parameter int NRD   = 2,
  localparam int GSH   = $clog2(GRP),
  localparam int NPHYS = 1 << PW
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic           wr_glob,
  input  logic [GSH-1:0] wr_off,
  input  logic [PW-1:0]  wr_phys,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_glob [NRD],
  input  logic [GSH-1:0] rd_off  [NRD],
  input  logic [PW-1:0]  rd_phys [NRD],
  output logic [DW-1:0]  rd_data [NRD]
);

  logic [DW-1:0] mem    [NPHYS];
  logic [DW-1:0] glob_q [GRP];

  // Windowed pool: no reset, one write port, so distributed RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en && !wr_glob) mem[wr_phys] <= wr_data;
  end

  // Globals. Entry 0 is never written.
  always_ff @(posedge clk) begin
    if (wr_en && wr_glob && (wr_off != '0)) glob_q[wr_off] <= wr_data;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      if (rd_glob[r]) rd_data[r] = (rd_off[r] == '0) ? '0 : glob_q[rd_off[r]];
      else            rd_data[r] = mem[rd_phys[r]];
    end
  end

endmodule

// File: rtl/winreg_wptr.sv
module winreg_wptr #(
  parameter int NWIN = 8,
  localparam int PTRW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_req,
  input  logic            ret_req,
  input  logic [NWIN-1:0] inval_mask,
  output logic [PTRW-1:0] cwp,
  output logic            ovf_flag,
  output logic            unf_flag
);

  logic [PTRW-1:0] up_w, dn_w;
  logic            do_adv, do_ret, adv_blk, ret_blk;

  always_comb begin
    up_w    = cwp + PTRW'(1);
    dn_w    = cwp - PTRW'(1);
    do_adv  = adv_req && !ret_req;
    do_ret  = ret_req && !adv_req;
    adv_blk = do_adv && inval_mask[up_w];
    ret_blk = do_ret && inval_mask[dn_w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      ovf_flag <= adv_blk;
      unf_flag <= ret_blk;
      if (do_adv && !adv_blk)      cwp <= up_w;
      else if (do_ret && !ret_blk) cwp <= dn_w;
    end
  end

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_req && !ret_req && !inval_mask[cwp + PTRW'(1)]) |=> (cwp == $past(cwp) + PTRW'(1))); // R5
  AST_RET_STEP: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !adv_req && !inval_mask[cwp - PTRW'(1)]) |=> (cwp == $past(cwp) - PTRW'(1))); // R5
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag || unf_flag) |-> (cwp == $past(cwp))); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_flag && unf_flag)); // R6
  AST_BOTH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (adv_req && ret_req) |=> ($stable(cwp) && !ovf_flag && !unf_flag)); // R7

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DW   = 32,
  parameter int NWIN = 8,
  parameter int GRP  = 8,
  localparam int PTRW = $clog2(NWIN),
  localparam int GSH  = $clog2(GRP),
  localparam int AW   = GSH + 2,
  localparam int PW   = PTRW + GSH + 1,
  localparam int NPRT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [DW-1:0]   rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            adv_req,
  input  logic            ret_req,
  input  logic [NWIN-1:0] inval_mask,
  output logic [PTRW-1:0] cwp,
  output logic            ovf_flag,
  output logic            unf_flag
);

  logic [AW-1:0]  p_idx  [NPRT];
  logic           p_glob [NPRT];
  logic [PW-1:0]  p_phys [NPRT];
  logic           r_glob [2];
  logic [GSH-1:0] r_off  [2];
  logic [PW-1:0]  r_phys [2];
  logic [DW-1:0]  r_data [2];

  assign p_idx[0] = rd_a_idx;
  assign p_idx[1] = rd_b_idx;
  assign p_idx[2] = wr_idx;

  winreg_wptr #(.NWIN(NWIN)) u_wptr (
    .clk(clk), .rst(rst), .adv_req(adv_req), .ret_req(ret_req),
    .inval_mask(inval_mask), .cwp(cwp), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  // One translator per port. The write port sees the pointer from before any move.
  for (genvar p = 0; p < NPRT; p++) begin : g_map
    winreg_map #(.NWIN(NWIN), .GRP(GRP)) u_map (
      .cwp(cwp), .idx(p_idx[p]), .is_glob(p_glob[p]), .phys(p_phys[p])
    );
  end

  for (genvar r = 0; r < 2; r++) begin : g_rport
    assign r_glob[r] = p_glob[r];
    assign r_off[r]  = p_idx[r][GSH-1:0];
    assign r_phys[r] = p_phys[r];
  end

  winreg_bank #(.DW(DW), .GRP(GRP), .PW(PW), .NRD(2)) u_bank (
    .clk(clk), .wr_en(wr_en), .wr_glob(p_glob[2]), .wr_off(wr_idx[GSH-1:0]),
    .wr_phys(p_phys[2]), .wr_data(wr_data),
    .rd_glob(r_glob), .rd_off(r_off), .rd_phys(r_phys), .rd_data(r_data)
  );

  assign rd_a_data = r_data[0];
  assign rd_b_data = r_data[1];

  AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0)); // R2
  AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (rd_b_data == '0)); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (cwp == '0 && !ovf_flag && !unf_flag)); // R1

endmodule

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, adv_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  inval_mask = '0;
  logic [2:0]  cwp;
  logic        ovf_flag, unf_flag;

  always #5 clk = ~clk;

  winreg_file u_dut (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .adv_req(adv_req), .ret_req(ret_req), .inval_mask(inval_mask),
    .cwp(cwp), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // Reference model
  logic [31:0] m_mem [128];
  bit          m_mv  [128];
  logic [31:0] m_glob[8];
  bit          m_gv  [8];
  int          m_cwp = 0;
  bit          m_ovf = 0, m_unf = 0;
  logic [31:0] ra_s, rb_s;

  function automatic int phys_of(int w, logic [4:0] idx);
    int off = int'(idx[2:0]);
    case (idx[4:3])
      2'd1:    return (w * 16 + off) % 128;
      2'd2:    return (w * 16 + 8 + off) % 128;
      default: return (((w + 7) % 8) * 16 + off) % 128;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_read(logic [4:0] idx, logic [31:0] act);
    if (idx == 0) chk("R2 zero read", act, 32'h0);
    else if (idx < 8) begin
      if (m_gv[idx[2:0]]) chk("R3 global read", act, m_glob[idx[2:0]]);
    end else begin
      int p = phys_of(m_cwp, idx);
      if (m_mv[p]) chk("R4 windowed read", act, m_mem[p]);
    end
  endtask

  task automatic cyc(bit sv, bit rs, bit we, logic [4:0] wi, logic [31:0] wd,
                     logic [4:0] ra, logic [4:0] rb, logic [7:0] mk);
    bit ds, dr;
    int up, dn;
    @(negedge clk);
    adv_req = sv; ret_req = rs; wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb; inval_mask = mk;
    #1;
    ra_s = rd_a_data; rb_s = rd_b_data;
    chk("R5 pointer", {29'd0, cwp}, m_cwp[31:0]);
    chk("R6 overflow flag", {31'd0, ovf_flag}, {31'd0, m_ovf});
    chk("R6 underflow flag", {31'd0, unf_flag}, {31'd0, m_unf});
    chk_read(ra, rd_a_data);
    chk_read(rb, rd_b_data);
    if (we) begin
      if (wi >= 8) begin
        int p = phys_of(m_cwp, wi);
        m_mem[p] = wd; m_mv[p] = 1;
      end else if (wi != 0) begin
        m_glob[wi[2:0]] = wd; m_gv[wi[2:0]] = 1;
      end
    end
    ds = sv && !rs; dr = rs && !sv;
    up = (m_cwp + 1) % 8; dn = (m_cwp + 7) % 8;
    m_ovf = ds && mk[up];
    m_unf = dr && mk[dn];
    if (ds && !mk[up]) m_cwp = up;
    else if (dr && !mk[dn]) m_cwp = dn;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) m_mv[i] = 0;
    for (int i = 0; i < 8; i++) m_gv[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pointer in reset", {29'd0, cwp}, 32'd0);
    chk("R1 ovf in reset", {31'd0, ovf_flag}, 32'd0);
    chk("R1 unf in reset", {31'd0, unf_flag}, 32'd0);
    @(negedge clk); rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // R2: write to register 0 ignored
    cyc(0, 0, 1, 5'd0, 32'hDEAD_BEEF, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 5'd0, 5'd0, 0);
    chk("R2 r0 after write", ra_s, 32'h0);

    // R9: read in the write cycle returns the old value
    cyc(0, 0, 1, 5'd16, 32'h1111_0001, 0, 0, 0);
    cyc(0, 0, 1, 5'd16, 32'h2222_0002, 5'd16, 0, 0);
    chk("R9 old value in write cycle", ra_s, 32'h1111_0001);
    cyc(0, 0, 0, 0, 0, 5'd16, 0, 0);
    chk("R9 new value next cycle", ra_s, 32'h2222_0002);

    // R8 / R4: write an out together with an advance, then read it as an in
    cyc(1, 0, 1, 5'd9, 32'hB0B0_0009, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 5'd25, 0, 0);
    chk("R8 write used old pointer", ra_s, 32'hB0B0_0009);
    chk("R4 out1 seen as in1", {29'd0, cwp}, 32'd1);

    // R3: globals survive a retreat
    cyc(0, 0, 1, 5'd5, 32'h6060_0005, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 5'd5, 0, 0);
    chk("R3 global after retreat", ra_s, 32'h6060_0005);

    // R6: blocked advance into window 1, blocked retreat into window 7
    cyc(1, 0, 0, 0, 0, 0, 0, 8'h02);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 ovf raised", {31'd0, ovf_flag}, 32'd1);
    chk("R6 pointer held on ovf", {29'd0, cwp}, 32'd0);
    cyc(0, 1, 0, 0, 0, 0, 0, 8'h80);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 unf raised", {31'd0, unf_flag}, 32'd1);
    chk("R6 pointer held on unf", {29'd0, cwp}, 32'd0);

    // R7: simultaneous requests
    cyc(1, 1, 0, 0, 0, 0, 0, 8'hFF);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 pointer unchanged", {29'd0, cwp}, 32'd0);
    chk("R7 no flag", {30'd0, ovf_flag, unf_flag}, 32'd0);

    // R10: eight advances wrap and leave locals intact
    cyc(0, 0, 1, 5'd20, 32'hC0DE_0020, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 pointer at 7", {29'd0, cwp}, 32'd7);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 5'd20, 0, 0);
    chk("R10 wrapped to 0", {29'd0, cwp}, 32'd0);
    chk("R10 local preserved", ra_s, 32'hC0DE_0020);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] mk = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      int op = $urandom % 8;
      cyc(op == 0 || op == 2, op == 1 || op == 2, ($urandom % 2) == 1,
          5'($urandom), $urandom, 5'($urandom), 5'($urandom), mk);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule